// File: doc/BRIEF.md
# Shared Floating-Point Unit Request Arbiter

This block lets several processor cores feed one pipelined floating-point unit. Every core presents a request made of an opcode, two 64-bit operands and a rounding mode, and holds it until it sees its grant pulse. Each cycle the arbiter chooses at most one request in fair round-robin order. Only a request whose operation class the unit currently allows can be chosen. The chosen request is registered and launched into the unit in the following cycle, together with an 8-bit operation tag.

The tag carries the core number in its upper three bits and that core's own 5-bit sequence count in its lower five bits. When the unit announces a completion, the arbiter decodes the announced tag. On the next cycle it raises a valid pulse towards the owning core, while the result, exception flags and condition code pass through on a shared bus. Operation cancellation is not used in this configuration, so the cancel line towards the unit stays low.

Top module: `fsa_share_arb`

## Requirements
- R1: After reset, no start is issued, no response valid is raised, every per-core sequence count is 0 and the round-robin pointer addresses core 0.
- R2: In any cycle at most one core sees `req_grant`, and only a core with `req_valid` high. The grant is combinational. On the next clock edge the winner's opcode, operands and rounding mode are registered, and `fpu_start` is high for exactly that following cycle.
- R3: The opcode class decides the grant. Codes 001001101, 001001110, 000101001 and 000101010 are iterative (divide or square root) and need `fpu_allow[0]`. Codes 001001001, 001001010 and 001101001 are multiplies and need `fpu_allow[1]`. Every other code needs `fpu_allow[2]`. The mask sampled in the grant cycle gates the start issued in the next cycle.
- R4: The search begins at the pointer and proceeds upward with wrap-around. After a grant, the pointer moves to the core just after the winner.
- R5: A requesting core that is skipped only because its class is blocked keeps its turn. If such a core lies between the pointer and the winner, the pointer moves to the first such core instead of past the winner.
- R6: `fpu_opid[7:5]` holds the granted core's number and `fpu_opid[4:0]` holds that core's sequence count. The count increments by one per grant to that core and wraps from 31 to 0.
- R7: `fpu_flush` is always 0.
- R8: If `fpu_ready` is high in a cycle, then in the next cycle exactly `rsp_valid[fpu_resid[7:5]]` is high. `rsp_seq` equals the announced `fpu_resid[4:0]`, and `rsp_result`, `rsp_except` and `rsp_cc` equal the unit's outputs in that cycle.
- R9: An announced tag whose core field is not below `NCORES` raises no response valid.
- R10: Issuing and returning are independent: a grant and a response in the same cycle are both served without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORES | Per-core request pending |
| req_opcode | input | NCORES*9 | Per-core opcode, core i in slice i |
| req_op1 | input | NCORES*64 | Per-core first operand |
| req_op2 | input | NCORES*64 | Per-core second operand |
| req_round | input | NCORES*2 | Per-core rounding mode |
| req_grant | output | NCORES | One-hot grant, request taken at this edge |
| fpu_allow | input | 3 | Unit's per-class allow mask for the next cycle |
| fpu_start | output | 1 | Launch an operation in the unit |
| fpu_opcode | output | 9 | Launched opcode |
| fpu_op1 | output | 64 | Launched first operand |
| fpu_op2 | output | 64 | Launched second operand |
| fpu_round | output | 2 | Launched rounding mode |
| fpu_opid | output | 8 | Launched tag {core, sequence} |
| fpu_flush | output | 1 | Cancel request, held at 0 |
| fpu_ready | input | 1 | Unit announces a result for the next cycle |
| fpu_resid | input | 8 | Tag of the announced result |
| fpu_result | input | 64 | Result from the unit |
| fpu_except | input | 6 | Exception flags from the unit |
| fpu_cc | input | 2 | Condition code from the unit |
| rsp_valid | output | NCORES | Per-core response pulse |
| rsp_seq | output | 5 | Sequence field of the returned tag |
| rsp_result | output | 64 | Result towards the cores |
| rsp_except | output | 6 | Exception flags towards the cores |
| rsp_cc | output | 2 | Condition code towards the cores |

## Verification
Issuing a new request and returning a finished result can fall in the same cycle, because they use separate registers and separate inputs. The bench raises `fpu_ready` with a tag for core 2 in the same cycle that core 1 is requesting. It then checks that core 1 is granted at once and launched on the next cycle with the expected tag, and that core 2's response pulse and data appear in that same next cycle. The blocked-class pointer rule is judged by a vector sequence in which the core holding the turn is blocked while a later core wins, followed by checks that the blocked core is served first once its class is allowed again.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam int OPC_W   = 9;
    localparam int DATA_W  = 64;
    localparam int RND_W   = 2;
    localparam int ID_W    = 8;
    localparam int CORE_FW = 3;
    localparam int SEQ_W   = ID_W - CORE_FW;
    localparam int EXC_W   = 6;
    localparam int CC_W    = 2;
    localparam int ALLOW_W = 3;
    localparam int MAX_CORES = 1 << CORE_FW;

    // operation classes; the value is the allow-mask bit that gates the class
    typedef enum logic [1:0] {
        CLS_ITER = 2'd0,
        CLS_MUL  = 2'd1,
        CLS_PIPE = 2'd2
    } op_class_e;

    localparam logic [OPC_W-1:0] OPC_DIV_SP  = 9'b001001101;
    localparam logic [OPC_W-1:0] OPC_DIV_DP  = 9'b001001110;
    localparam logic [OPC_W-1:0] OPC_SQRT_SP = 9'b000101001;
    localparam logic [OPC_W-1:0] OPC_SQRT_DP = 9'b000101010;
    localparam logic [OPC_W-1:0] OPC_MUL_SP  = 9'b001001001;
    localparam logic [OPC_W-1:0] OPC_MUL_DP  = 9'b001001010;
    localparam logic [OPC_W-1:0] OPC_MUL_WD  = 9'b001101001;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] op2;
        logic [RND_W-1:0]  rnd;
        logic [ID_W-1:0]   id;
    } issue_t;

    function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
        op_class_e c;
        case (opc)
            OPC_DIV_SP, OPC_DIV_DP, OPC_SQRT_SP, OPC_SQRT_DP: c = CLS_ITER;
            OPC_MUL_SP, OPC_MUL_DP, OPC_MUL_WD:               c = CLS_MUL;
            default:                                          c = CLS_PIPE;
        endcase
        return c;
    endfunction

    function automatic logic class_allowed(input logic [OPC_W-1:0] opc,
                                           input logic [ALLOW_W-1:0] allow);
        return allow[classify(opc)];
    endfunction

endpackage

// File: rtl/fsa_rr_pick.sv
// Finds the first set bit of mask, searching upward from base with wrap.
module fsa_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = base;
        // descending offsets so the nearest candidate is written last
        for (int k = N - 1; k >= 0; k--) begin
            int s;
            s = int'(base) + k;
            if (s >= N) s = s - N;
            if (mask[s]) begin
                found = 1'b1;
                idx   = s[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/fsa_seq_bank.sv
// One wrap-around sequence counter per core.
module fsa_seq_bank #(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int SEQ_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [IW-1:0]    inc_idx,
    output logic [N*SEQ_W-1:0] seq_flat
);
    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic [SEQ_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (inc_en && (int'(inc_idx) == i))
                cnt_q <= cnt_q + 1'b1;
        end
        assign seq_flat[i*SEQ_W +: SEQ_W] = cnt_q;
    end
endmodule

// File: rtl/fsa_ret_steer.sv
// Captures the announced tag and raises the owning core's pulse one cycle later.
module fsa_ret_steer #(
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ready,
    input  logic [fsa_pkg::ID_W-1:0]  resid,
    output logic [N-1:0]              rsp_valid,
    output logic [fsa_pkg::SEQ_W-1:0] rsp_seq
);
    import fsa_pkg::*;

    logic            rdy_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            id_q  <= '0;
        end else begin
            rdy_q <= ready;
            if (ready) id_q <= resid;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign rsp_valid[i] = rdy_q && (int'(id_q[ID_W-1 -: CORE_FW]) == i);
    end

    assign rsp_seq = id_q[SEQ_W-1:0];
endmodule

// File: rtl/fsa_share_arb.sv
module fsa_share_arb #(
    parameter int NCORES = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NCORES-1:0]                    req_valid,
    input  logic [NCORES*fsa_pkg::OPC_W-1:0]     req_opcode,
    input  logic [NCORES*fsa_pkg::DATA_W-1:0]    req_op1,
    input  logic [NCORES*fsa_pkg::DATA_W-1:0]    req_op2,
    input  logic [NCORES*fsa_pkg::RND_W-1:0]     req_round,
    output logic [NCORES-1:0]                    req_grant,
    input  logic [fsa_pkg::ALLOW_W-1:0]          fpu_allow,
    output logic                                 fpu_start,
    output logic [fsa_pkg::OPC_W-1:0]            fpu_opcode,
    output logic [fsa_pkg::DATA_W-1:0]           fpu_op1,
    output logic [fsa_pkg::DATA_W-1:0]           fpu_op2,
    output logic [fsa_pkg::RND_W-1:0]            fpu_round,
    output logic [fsa_pkg::ID_W-1:0]             fpu_opid,
    output logic                                 fpu_flush,
    input  logic                                 fpu_ready,
    input  logic [fsa_pkg::ID_W-1:0]             fpu_resid,
    input  logic [fsa_pkg::DATA_W-1:0]           fpu_result,
    input  logic [fsa_pkg::EXC_W-1:0]            fpu_except,
    input  logic [fsa_pkg::CC_W-1:0]             fpu_cc,
    output logic [NCORES-1:0]                    rsp_valid,
    output logic [fsa_pkg::SEQ_W-1:0]            rsp_seq,
    output logic [fsa_pkg::DATA_W-1:0]           rsp_result,
    output logic [fsa_pkg::EXC_W-1:0]            rsp_except,
    output logic [fsa_pkg::CC_W-1:0]             rsp_cc
);
    import fsa_pkg::*;

    localparam int IW = (NCORES > 1) ? $clog2(NCORES) : 1;

    // ---------------- eligibility ----------------
    logic [NCORES-1:0] cls_ok;
    logic [NCORES-1:0] eligible;

    for (genvar i = 0; i < NCORES; i++) begin : g_cls
        assign cls_ok[i] = class_allowed(req_opcode[i*OPC_W +: OPC_W], fpu_allow);
    end
    assign eligible = req_valid & cls_ok;

    // ---------------- round-robin search ----------------
    logic [IW-1:0] ptr_q;
    logic          any_req, win_found;
    logic [IW-1:0] first_req_idx, win_idx;

    fsa_rr_pick #(.N(NCORES), .IW(IW)) u_pick_req (
        .mask (req_valid),
        .base (ptr_q),
        .found(any_req),
        .idx  (first_req_idx)
    );

    fsa_rr_pick #(.N(NCORES), .IW(IW)) u_pick_win (
        .mask (eligible),
        .base (ptr_q),
        .found(win_found),
        .idx  (win_idx)
    );

    always_comb begin
        req_grant = '0;
        if (win_found) req_grant[win_idx] = 1'b1;
    end

    function automatic logic [IW-1:0] next_core(input logic [IW-1:0] c);
        return (int'(c) == NCORES - 1) ? '0 : c + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (win_found) begin
            // a blocked requester ahead of the winner keeps the turn
            if (first_req_idx == win_idx)
                ptr_q <= next_core(win_idx);
            else
                ptr_q <= first_req_idx;
        end
    end

    // ---------------- sequence counters ----------------
    logic [NCORES*SEQ_W-1:0] seq_flat;

    fsa_seq_bank #(.N(NCORES), .IW(IW), .SEQ_W(SEQ_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (win_found),
        .inc_idx (win_idx),
        .seq_flat(seq_flat)
    );

    // ---------------- issue register ----------------
    issue_t issue_d, issue_q;
    logic   start_q;

    always_comb begin
        issue_d.opcode = req_opcode[int'(win_idx)*OPC_W  +: OPC_W];
        issue_d.op1    = req_op1   [int'(win_idx)*DATA_W +: DATA_W];
        issue_d.op2    = req_op2   [int'(win_idx)*DATA_W +: DATA_W];
        issue_d.rnd    = req_round [int'(win_idx)*RND_W  +: RND_W];
        issue_d.id     = {CORE_FW'(win_idx), seq_flat[int'(win_idx)*SEQ_W +: SEQ_W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            issue_q <= '0;
        end else begin
            start_q <= win_found;
            if (win_found) issue_q <= issue_d;
        end
    end

    assign fpu_start  = start_q;
    assign fpu_opcode = issue_q.opcode;
    assign fpu_op1    = issue_q.op1;
    assign fpu_op2    = issue_q.op2;
    assign fpu_round  = issue_q.rnd;
    assign fpu_opid   = issue_q.id;
    assign fpu_flush  = 1'b0;

    // ---------------- result return ----------------
    fsa_ret_steer #(.N(NCORES)) u_ret (
        .clk      (clk),
        .rst      (rst),
        .ready    (fpu_ready),
        .resid    (fpu_resid),
        .rsp_valid(rsp_valid),
        .rsp_seq  (rsp_seq)
    );

    assign rsp_result = fpu_result;
    assign rsp_except = fpu_except;
    assign rsp_cc     = fpu_cc;

endmodule

// File: rtl/fsa_checker.sv
module fsa_checker #(
    parameter int NCORES = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NCORES-1:0]            req_valid,
    input logic [NCORES-1:0]            req_grant,
    input logic [fsa_pkg::ALLOW_W-1:0]  fpu_allow,
    input logic                         fpu_start,
    input logic [fsa_pkg::OPC_W-1:0]    fpu_opcode,
    input logic [fsa_pkg::ID_W-1:0]     fpu_opid,
    input logic                         fpu_flush,
    input logic                         fpu_ready,
    input logic [fsa_pkg::ID_W-1:0]     fpu_resid,
    input logic [NCORES-1:0]            rsp_valid
);
    import fsa_pkg::*;

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant));

    assert_grant_requested_R2: assert property (@(posedge clk) disable iff (rst)
        (req_grant & ~req_valid) == '0);

    assert_start_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (|req_grant) |=> fpu_start);

    assert_no_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
        !(|req_grant) |=> !fpu_start);

    assert_class_allowed_R3: assert property (@(posedge clk) disable iff (rst)
        (|req_grant) |=> class_allowed(fpu_opcode, $past(fpu_allow)));

    assert_tag_core_R6: assert property (@(posedge clk) disable iff (rst)
        (|req_grant) |=> ($past(req_grant) == (NCORES'(1) << fpu_opid[ID_W-1 -: CORE_FW])));

    assert_no_flush_R7: assert property (@(posedge clk) disable iff (rst)
        fpu_flush == 1'b0);

    assert_rsp_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));

    assert_rsp_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (|rsp_valid) |-> $past(fpu_ready));

    // R8 and R9: owning core pulses, out-of-range core field pulses nobody
    assert_rsp_steer_R8: assert property (@(posedge clk) disable iff (rst)
        fpu_ready |=> (rsp_valid ==
            ((int'($past(fpu_resid[ID_W-1 -: CORE_FW])) < NCORES)
                ? (NCORES'(1) << $past(fpu_resid[ID_W-1 -: CORE_FW])) : '0)));

endmodule

bind fsa_share_arb fsa_checker #(.NCORES(NCORES)) u_fsa_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_grant (req_grant),
    .fpu_allow (fpu_allow),
    .fpu_start (fpu_start),
    .fpu_opcode(fpu_opcode),
    .fpu_opid  (fpu_opid),
    .fpu_flush (fpu_flush),
    .fpu_ready (fpu_ready),
    .fpu_resid (fpu_resid),
    .rsp_valid (rsp_valid)
);

// File: tb/fsa_share_arb_tb_top.sv
`timescale 1ns/1ps
module fsa_share_arb_tb_top;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_valid = '0;
    logic [N*9-1:0]  req_opcode;
    logic [N*64-1:0] req_op1, req_op2;
    logic [N*2-1:0]  req_round;
    logic [N-1:0]    req_grant;
    logic [2:0]      fpu_allow = 3'b111;
    logic            fpu_start;
    logic [8:0]      fpu_opcode;
    logic [63:0]     fpu_op1, fpu_op2;
    logic [1:0]      fpu_round;
    logic [7:0]      fpu_opid;
    logic            fpu_flush;
    logic            fpu_ready = 1'b0;
    logic [7:0]      fpu_resid = '0;
    logic [63:0]     fpu_result = '0;
    logic [5:0]      fpu_except = '0;
    logic [1:0]      fpu_cc = '0;
    logic [N-1:0]    rsp_valid;
    logic [4:0]      rsp_seq;
    logic [63:0]     rsp_result;
    logic [5:0]      rsp_except;
    logic [1:0]      rsp_cc;

    always #2 clk = ~clk;

    fsa_share_arb #(.NCORES(N)) dut_i (.*);

    int checks = 0;
    int errors = 0;
    int seq_m [N];

    // core opcodes: add (other), multiply, divide, int-to-float (other)
    localparam logic [8:0] CORE_OPC [N] = '{9'b001000001, 9'b001001001,
                                            9'b001001101, 9'b011000100};

    // {req_valid[3:0], allow[2:0], expected grant[3:0]}
    localparam logic [10:0] VEC [0:11] = '{
        {4'b1111, 3'b111, 4'b0001},
        {4'b1111, 3'b111, 4'b0010},
        {4'b1111, 3'b110, 4'b1000},
        {4'b1111, 3'b111, 4'b0100},
        {4'b1111, 3'b111, 4'b1000},
        {4'b0000, 3'b111, 4'b0000},
        {4'b0110, 3'b111, 4'b0010},
        {4'b0011, 3'b011, 4'b0010},
        {4'b0011, 3'b111, 4'b0001},
        {4'b1001, 3'b000, 4'b0000},
        {4'b1001, 3'b100, 4'b1000},
        {4'b0101, 3'b001, 4'b0100}
    };

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int onehot_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    // sample at +1 after the edge: check the launched operation of core c
    task automatic chk_launch(input int c, input string tag);
        logic [7:0] exp_id;
        exp_id = {3'(c), 5'(seq_m[c])};
        chk(fpu_start === 1'b1, {tag, " start"}, 64'(fpu_start), 1);
        chk(fpu_opid === exp_id, {tag, " opid"}, 64'(fpu_opid), 64'(exp_id));
        chk(fpu_opcode === CORE_OPC[c], {tag, " opcode"}, 64'(fpu_opcode), 64'(CORE_OPC[c]));
        chk(fpu_op1 === req_op1[c*64 +: 64], {tag, " op1"}, fpu_op1, req_op1[c*64 +: 64]);
        chk(fpu_round === 2'(c), {tag, " round"}, 64'(fpu_round), 64'(c));
        chk(fpu_flush === 1'b0, "R7 flush", 64'(fpu_flush), 0);
        seq_m[c] = (seq_m[c] + 1) % 32;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            req_opcode[i*9 +: 9] = CORE_OPC[i];
            req_op1[i*64 +: 64]  = {32'hA000_0000 + 32'(i), 32'h0000_1234};
            req_op2[i*64 +: 64]  = ~{32'hA000_0000 + 32'(i), 32'h0000_1234};
            req_round[i*2 +: 2]  = 2'(i);
            seq_m[i] = 0;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(fpu_start === 1'b0, "R1 no start after reset", 64'(fpu_start), 0);
        chk(rsp_valid === '0, "R1 no response after reset", 64'(rsp_valid), 0);

        // table walk: pointer sequence, class gating, blocked-turn retention
        foreach (VEC[v]) begin
            logic [3:0] exp_g;
            @(negedge clk);
            req_valid = VEC[v][10:7];
            fpu_allow = VEC[v][6:4];
            exp_g     = VEC[v][3:0];
            #1;
            chk(req_grant === exp_g, $sformatf("R4/R5/R3 grant vec%0d", v),
                64'(req_grant), 64'(exp_g));
            @(posedge clk); #1;
            if (exp_g != 0)
                chk_launch(onehot_idx(exp_g), $sformatf("R2/R6 vec%0d", v));
            else
                chk(fpu_start === 1'b0, $sformatf("R2 idle vec%0d", v), 64'(fpu_start), 0);
        end

        // R6: sequence wrap for core 0
        fpu_allow = 3'b111;
        for (int k = 0; k < 36; k++) begin
            @(negedge clk);
            req_valid = 4'b0001;
            #1;
            chk(req_grant === 4'b0001, "R2 lone requester", 64'(req_grant), 1);
            @(posedge clk); #1;
            chk_launch(0, "R6 wrap");
        end
        @(negedge clk);
        req_valid = '0;

        // R10 + R8: response for core 2 while core 1 is granted
        @(negedge clk);
        req_valid = 4'b0010;
        fpu_ready = 1'b1;
        fpu_resid = {3'd2, 5'd7};
        #1;
        chk(req_grant === 4'b0010, "R10 grant beside ready", 64'(req_grant), 2);
        @(posedge clk); #1;
        fpu_ready  = 1'b0;
        fpu_result = 64'hDEAD_BEEF_0123_4567;
        fpu_except = 6'h15;
        fpu_cc     = 2'b10;
        #0.5;
        chk(rsp_valid === 4'b0100, "R8 steer to core 2", 64'(rsp_valid), 4);
        chk(rsp_seq === 5'd7, "R8 seq field", 64'(rsp_seq), 7);
        chk(rsp_result === 64'hDEAD_BEEF_0123_4567, "R8 result", rsp_result, 64'hDEAD_BEEF_0123_4567);
        chk(rsp_except === 6'h15, "R8 except", 64'(rsp_except), 64'h15);
        chk(rsp_cc === 2'b10, "R8 cc", 64'(rsp_cc), 2);
        chk_launch(1, "R10 launch beside response");
        @(negedge clk);
        req_valid = '0;
        @(posedge clk); #1;
        chk(rsp_valid === '0, "R8 single pulse", 64'(rsp_valid), 0);

        // R8: core 3, top sequence value
        @(negedge clk);
        fpu_ready = 1'b1;
        fpu_resid = {3'd3, 5'd31};
        @(posedge clk); #1;
        fpu_ready = 1'b0;
        #0.5;
        chk(rsp_valid === 4'b1000, "R8 steer to core 3", 64'(rsp_valid), 8);
        chk(rsp_seq === 5'd31, "R8 seq 31", 64'(rsp_seq), 31);

        // R9: core field beyond the core count
        @(negedge clk);
        fpu_ready = 1'b1;
        fpu_resid = {3'd5, 5'd1};
        @(posedge clk); #1;
        fpu_ready = 1'b0;
        chk(rsp_valid === '0, "R9 out-of-range core", 64'(rsp_valid), 0);

        // R1: reset clears pointer and counters
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(fpu_start === 1'b0, "R1 start cleared in reset", 64'(fpu_start), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) seq_m[i] = 0;
        req_valid = 4'b1111;
        #1;
        chk(req_grant === 4'b0001, "R1 pointer at core 0", 64'(req_grant), 1);
        @(posedge clk); #1;
        chk_launch(0, "R1 counter cleared");
        @(negedge clk);
        req_valid = '0;
        @(posedge clk); #1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule